// File: doc/BRIEF.md
# Transparent Serial Receiver with Pattern Alignment

This block turns a raw serial bit stream into bytes without interpreting the contents. Each accepted bit is kept unchanged, and the first bit of a byte becomes its least significant bit. A completed byte appears on a one-cycle write strobe with its data, ready for a downstream store.

The block starts packing only while a frame-lock input is high. In pass-through mode, byte boundaries count from the first valid bit after lock is taken. In match mode, the block first searches the incoming stream for a programmable pattern. The search checks the last `BYTE_W` bits at every bit position, not only at byte boundaries. When the pattern is found, the matched byte is written out, and byte boundaries are re-anchored so that every later byte follows on directly. A receive-reset command throws away any partial work. In match mode it restarts the search; in pass-through mode it restarts the byte count.

The controller has three states:
- `ST_UNLOCKED` waits for lock.
- `ST_SEARCH` slides the window looking for the pattern.
- `ST_PACK` assembles bytes.

Transitions:
- Any state goes to `ST_UNLOCKED` when lock is low. This has the highest priority.
- Any state goes to `ST_SEARCH` or `ST_PACK` on a receive reset, the choice depending on the match-mode input. This comes second.
- `ST_UNLOCKED` goes to `ST_SEARCH` or `ST_PACK` once lock is seen, again depending on the match-mode input.
- `ST_SEARCH` goes to `ST_PACK` on a pattern hit.

The match-mode input is sampled only on these lock and reset transitions.

Top module: `rxt_rx`

## Requirements
- R1: After reset `byte_vld` is 0 and the block is unlocked.
- R2: While `frm_lock` is low no byte is produced. Bits presented in the cycle in which lock is first seen high are discarded.
- R3: Bits are packed least significant bit first: the first accepted bit of a byte lands in `byte_dat[0]`. `byte_vld` is a single-cycle pulse in the cycle after the clock edge that accepted the byte's last bit.
- R4: With `match_en` low, the first valid bit after lock is taken starts byte 0. Every following group of `BYTE_W` valid bits forms the next byte.
- R5: With `match_en` high, no byte is produced while the pattern has not yet been found.
- R6: The pattern is compared with the most recent `BYTE_W` accepted bits, the oldest in bit 0, at every bit position. A hit needs at least `BYTE_W` bits accepted since the search began.
- R7: On a hit, `byte_dat` equals `match_val`. Later bytes are aligned from the bit that follows the matched pattern.
- R8: A receive reset with `match_en` high discards the partial byte, empties the window and restarts the search. The bit presented in that cycle is discarded.
- R9: A receive reset with `match_en` low discards the partial byte and restarts the byte count at the next valid bit. No byte is produced in the following cycle.
- R10: Losing lock clears any partly assembled byte. After lock returns, alignment starts afresh.
- R11: Cycles with `bit_vld` low change neither the window nor the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| frm_lock | input | 1 | High while frame alignment is held |
| match_en | input | 1 | Selects match mode (sampled on lock and receive reset) |
| match_val | input | BYTE_W | Pattern to search for, oldest bit in bit 0 |
| rx_reset | input | 1 | Receive-reset command, one cycle |
| byte_vld | output | 1 | Byte write strobe |
| byte_dat | output | BYTE_W | Byte data, valid with `byte_vld` |

## Verification
The bench builds the block with `BYTE_W` = 8, so byte values and match patterns can be written as ordinary hex octets.

A pattern placed three bits off the packing grid shows that the search slides rather than stepping by bytes. An all-zero pattern sent right after a reset, into an emptied window, exposes any hit taken before the window is full.

Idle gaps between bits, a lock drop in the middle of a byte, and receive resets in both modes each reach a different abort path. A scoreboard checks the order and value of every byte written.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_SEARCH   = 2'd1,
        ST_PACK     = 2'd2
    } rxt_state_e;
endpackage

// File: rtl/rxt_shift.sv
// Shared window / assembly register: new bits enter at the MSB end.
module rxt_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              din,
    output logic [BYTE_W-1:0] win_nxt
);
    logic [BYTE_W-1:0] win_q;

    assign win_nxt = {din, win_q[BYTE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (clr) begin
            win_q <= '0;
        end else if (shift) begin
            win_q <= win_nxt;
        end
    end
endmodule

// File: rtl/rxt_bitcnt.sv
// Counts accepted bits, saturating at BYTE_W; flags the bit that completes a group.
module rxt_bitcnt #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);
    localparam logic [CW-1:0] LASTV = CW'(BYTE_W - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q >= LASTV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxt_fsm.sv
module rxt_fsm
    import rxt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_lock,
    input  logic       rx_reset,
    input  logic       match_en,
    input  logic       bit_vld,
    input  logic       last,
    input  logic       hit,
    output rxt_state_e st,
    output logic       shift,
    output logic       cnt_clr,
    output logic       win_clr,
    output logic       emit
);
    rxt_state_e st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_UNLOCKED;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        shift   = 1'b0;
        cnt_clr = 1'b0;
        win_clr = 1'b0;
        emit    = 1'b0;
        if (!frm_lock) begin
            st_nxt  = ST_UNLOCKED;
            cnt_clr = 1'b1;
            win_clr = 1'b1;
        end else if (rx_reset) begin
            st_nxt  = match_en ? ST_SEARCH : ST_PACK;
            cnt_clr = 1'b1;
            win_clr = 1'b1;
        end else begin
            unique case (st)
                ST_UNLOCKED: begin
                    st_nxt  = match_en ? ST_SEARCH : ST_PACK;
                    cnt_clr = 1'b1;
                    win_clr = 1'b1;
                end
                ST_SEARCH: begin
                    if (bit_vld) begin
                        shift = 1'b1;
                        if (last && hit) begin
                            emit    = 1'b1;
                            cnt_clr = 1'b1;
                            st_nxt  = ST_PACK;
                        end
                    end
                end
                ST_PACK: begin
                    if (bit_vld) begin
                        shift = 1'b1;
                        if (last) begin
                            emit    = 1'b1;
                            cnt_clr = 1'b1;
                        end
                    end
                end
                default: begin
                    st_nxt  = ST_UNLOCKED;
                    cnt_clr = 1'b1;
                    win_clr = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/rxt_rx.sv
module rxt_rx
    import rxt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              frm_lock,
    input  logic              match_en,
    input  logic [BYTE_W-1:0] match_val,
    input  logic              rx_reset,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_dat
);
    rxt_state_e        st;
    logic              shift, cnt_clr, win_clr, emit, last, hit;
    logic [BYTE_W-1:0] win_nxt;

    assign hit = (win_nxt == match_val);

    rxt_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_clr),
        .shift   (shift),
        .din     (bit_in),
        .win_nxt (win_nxt)
    );

    rxt_bitcnt #(.BYTE_W(BYTE_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (shift),
        .last  (last)
    );

    rxt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_lock (frm_lock),
        .rx_reset (rx_reset),
        .match_en (match_en),
        .bit_vld  (bit_vld),
        .last     (last),
        .hit      (hit),
        .st       (st),
        .shift    (shift),
        .cnt_clr  (cnt_clr),
        .win_clr  (win_clr),
        .emit     (emit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_vld <= 1'b0;
            byte_dat <= '0;
        end else begin
            byte_vld <= emit;
            if (emit) begin
                byte_dat <= win_nxt;
            end
        end
    end
endmodule

// File: rtl/rxt_rx_chk.sv
module rxt_rx_chk
    import rxt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              frm_lock,
    input logic              match_en,
    input logic [BYTE_W-1:0] match_val,
    input logic              rx_reset,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_dat,
    input rxt_state_e        st
);
    // R2
    no_out_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_lock |=> !byte_vld);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R11
    out_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(bit_vld));

    // R5
    search_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEARCH) |-> !byte_vld);

    // R7
    match_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && $past(st == ST_SEARCH)) |-> (byte_dat == $past(match_val)));

    // R8
    research_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_lock && rx_reset && match_en) |=> (st == ST_SEARCH));

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> !byte_vld);
endmodule

bind rxt_rx rxt_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .frm_lock  (frm_lock),
    .match_en  (match_en),
    .match_val (match_val),
    .rx_reset  (rx_reset),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .st        (st)
);

// File: tb/tb_rxt_rx.sv
module tb_rxt_rx;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic          bit_vld = 1'b0;
    logic          frm_lock = 1'b0;
    logic          match_en = 1'b0;
    logic [BW-1:0] match_val = '0;
    logic          rx_reset = 1'b0;
    logic          byte_vld;
    logic [BW-1:0] byte_dat;

    int n_chk = 0;
    int n_fail = 0;
    logic [BW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    rxt_rx #(.BYTE_W(BW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .frm_lock  (frm_lock),
        .match_en  (match_en),
        .match_val (match_val),
        .rx_reset  (rx_reset),
        .byte_vld  (byte_vld),
        .byte_dat  (byte_dat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: pops the scoreboard on each written byte
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", int'(byte_dat), 0);
            end else begin
                logic [BW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(byte_dat == e, t, int'(byte_dat), int'(e));
            end
        end
    end

    task automatic bitc(input logic b, input logic v);
        @(negedge clk);
        bit_in  = b;
        bit_vld = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bitc(1'b0, 1'b0);
    endtask

    task automatic send_byte(input logic [BW-1:0] d, input bit expect_it, input string tag,
                             input bit gaps);
        if (expect_it) begin
            exp_q.push_back(d);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < BW; i++) begin
            bitc(d[i], 1'b1);
            if (gaps && (i % 3 == 1)) bitc(1'b1, 1'b0);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rx_reset = 1'b1;
        bit_in   = 1'b1;
        bit_vld  = 1'b1;
        @(negedge clk);
        rx_reset = 1'b0;
        bit_vld  = 1'b0;
    endtask

    task automatic drain(input string tag);
        idle(4);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(byte_vld == 1'b0, "R1 reset byte_vld", int'(byte_vld), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: bits while unlocked are ignored
        for (int i = 0; i < 10; i++) bitc(1'b1, 1'b1);
        drain("R2 no output unlocked");

        // R2/R4: lock taken with a bit in the same cycle (discarded)
        @(negedge clk);
        frm_lock = 1'b1;
        bit_in   = 1'b1;
        bit_vld  = 1'b1;
        send_byte(8'hA5, 1'b1, "R4 R3 first byte", 1'b0);
        send_byte(8'h3C, 1'b1, "R11 gapped byte", 1'b1);
        drain("R4 pass-through drain");

        // R10: lock lost mid-byte clears the partial byte
        bitc(1'b1, 1'b1); bitc(1'b0, 1'b1); bitc(1'b1, 1'b1);
        bitc(1'b1, 1'b1); bitc(1'b1, 1'b1);
        @(negedge clk);
        frm_lock = 1'b0;
        bit_vld  = 1'b0;
        for (int i = 0; i < 4; i++) bitc(1'b0, 1'b1);
        @(negedge clk);
        frm_lock = 1'b1;
        bit_vld  = 1'b0;
        send_byte(8'h81, 1'b1, "R10 realigned after relock", 1'b0);
        drain("R10 drain");

        // R9: receive reset in pass-through restarts the count
        bitc(1'b1, 1'b1); bitc(1'b1, 1'b1); bitc(1'b1, 1'b1);
        pulse_reset();
        send_byte(8'h5A, 1'b1, "R9 count restarted", 1'b0);
        drain("R9 drain");

        // R5/R6/R7: pattern three bits off the grid
        @(negedge clk);
        match_en  = 1'b1;
        match_val = 8'h7E;
        pulse_reset();
        bitc(1'b1, 1'b1); bitc(1'b0, 1'b1); bitc(1'b1, 1'b1);
        send_byte(8'h7E, 1'b1, "R6 R7 matched byte", 1'b0);
        send_byte(8'h12, 1'b1, "R7 byte after match", 1'b0);
        drain("R5 R7 drain");

        // R6: all-zero pattern must wait for a full window
        @(negedge clk);
        match_val = 8'h00;
        pulse_reset();
        bitc(1'b0, 1'b1); bitc(1'b0, 1'b1); bitc(1'b0, 1'b1); bitc(1'b1, 1'b1);
        exp_q.push_back(8'h00);
        tag_q.push_back("R6 full window zero match");
        for (int i = 0; i < 8; i++) bitc(1'b0, 1'b1);
        send_byte(8'hFF, 1'b1, "R7 after zero match", 1'b0);
        drain("R6 drain");

        // R8: receive reset in match mode restarts the search
        @(negedge clk);
        match_val = 8'h7E;
        bitc(1'b1, 1'b1); bitc(1'b1, 1'b1); bitc(1'b1, 1'b1); bitc(1'b1, 1'b1);
        pulse_reset();
        bitc(1'b0, 1'b1); bitc(1'b0, 1'b1);
        send_byte(8'h7E, 1'b1, "R8 rematched byte", 1'b0);
        send_byte(8'h34, 1'b1, "R8 byte after rematch", 1'b0);
        drain("R8 drain");

        // R5: no pattern present, nothing written
        pulse_reset();
        for (int i = 0; i < 20; i++) bitc(1'b1, 1'b1);
        drain("R5 silent search");

        finish_run();
    end
endmodule